// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block is the single write port for the paging and mode control registers of a processor core: CR0, CR2, CR3, CR4, CR8, the extended feature register (EFER) and the code-segment attribute word. It also holds the ES, CS, SS, DS, FS and GS segment base registers. Each write is stored with its architectural side effects. The block raises TLB flush requests, keeps the long-mode-active flag in step with paging, and keeps the effective segment bases consistent with 64-bit mode. The TLBs and the translation logic sit outside the block. They only see the flush pulses and the register values.

One write arrives per cycle as an enable, a 5-bit index and a data word. All results appear after the next rising clock edge. Flush and error outputs are one-cycle pulses in the cycle after the write. The side effects are found by comparing the stored value with the incoming one, so the same data word can flush or not depending on history.

Top module: `cr_side_unit`

## Requirements
- R1: After reset, CR0 reads 0x00000010 (bit 4 set). Every other register, every stored base and every effective base reads 0, and all pulse outputs are low.
- R2: A write to CR0 stores the written word with bit 4 forced to 1.
- R3: A CR0 write that changes bit 31 (paging) while EFER bit 8 (long enable) is 1 sets EFER bit 10 (long active) to the new bit 31 value. With EFER bit 8 at 0, EFER bit 10 is left as it was.
- R4: A CR0 write that changes bit 31 makes `flush_all` high for exactly the one cycle after the write. `flush_all` is low in every cycle that does not follow a flushing write.
- R5: Every CR3 write makes `flush_nonglobal` high for the one cycle after the write, even when the value is unchanged, and does not raise `flush_all`.
- R6: A CR4 write that changes bit 4, 5 or 7 raises `flush_all` for one cycle. A CR4 write that changes only other bits stores the value and raises no flush.
- R7: A code-segment attribute write whose bit 0 (long) goes 0 to 1 clears the effective bases of ES, CS, SS and DS. A write whose bit 0 goes 1 to 0 reloads those four from their stored bases. A write that keeps bit 0 leaves every effective base as it was. FS and GS effective bases are never touched by attribute writes.
- R8: A write to the ES, CS, SS or DS base always updates the stored base. It updates the matching effective base only when EFER bit 10 is 0 or attribute bit 0 is 0.
- R9: A write to the FS or GS base updates both the stored and the effective base in every mode.
- R10: Indices 1, 5 to 7, 9 to 15 and 24 to 31 are illegal. Writing one raises `wr_illegal` for the one cycle after the write, raises no flush and changes no register.
- R11: Index map: 0 to 15 are CRn, 16 is EFER, 17 is the code-segment attribute, and 18 to 23 are the bases of ES, CS, SS, DS, FS and GS in that order. CR2, CR8 and EFER store the written word unchanged. Nothing changes and no pulse rises while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register index (R11 map) |
| wr_data | input | DW | Write data |
| cr0_q | output | DW | CR0 value |
| cr2_q | output | DW | CR2 value |
| cr3_q | output | DW | CR3 value |
| cr4_q | output | DW | CR4 value |
| cr8_q | output | DW | CR8 value |
| efer_q | output | DW | Extended feature register value |
| cs_attr_q | output | DW | Code-segment attribute word |
| seg_base_q | output | 6*DW | Stored bases, ES in the low word up to GS |
| seg_eff_q | output | 6*DW | Effective bases, same packing |
| flush_all | output | 1 | Full flush of both TLBs, one-cycle pulse |
| flush_nonglobal | output | 1 | Non-global flush of both TLBs, one-cycle pulse |
| wr_illegal | output | 1 | Illegal index pulse |

## Verification
The hardest case to reach is a segment base write made while long mode is active and the code segment is in long mode. The write must land in the stored base but stay hidden from the effective base until the long attribute drops and the reload exposes it. To get there, the bench sets EFER bit 8, turns paging on, raises the attribute long bit, and writes all six bases. It then clears the long bit and compares the reloaded effective bases with the stored ones. It repeats this across all four combinations of long-active and attribute-long, and also sweeps every single-bit CR4 toggle and every illegal index against a model of all outputs.

// File: rtl/cr_side_pkg.sv
package cr_side_pkg;
  localparam int IDX_W    = 5;
  localparam int NSEG     = 6;   // ES CS SS DS FS GS
  localparam int NGATED   = 4;   // first four are mode-gated
  localparam int CR0_ET   = 4;
  localparam int CR0_PG   = 31;
  localparam int CR4_PSE  = 4;
  localparam int CR4_PAE  = 5;
  localparam int CR4_PGE  = 7;
  localparam int EFER_LME = 8;
  localparam int EFER_LMA = 10;
  localparam int CSA_LONG = 0;
  localparam int IDX_EFER = 16;
  localparam int IDX_CSA  = 17;
  localparam int IDX_SEG0 = 18;

  typedef enum logic [3:0] {
    K_NONE, K_CR0, K_CR2, K_CR3, K_CR4, K_CR8, K_EFER, K_CSA, K_SEG, K_ILL
  } wr_kind_e;

  function automatic wr_kind_e classify(input logic [IDX_W-1:0] idx);
    wr_kind_e k;
    if (int'(idx) < 16) begin
      case (idx[3:0])
        4'd0:    k = K_CR0;
        4'd2:    k = K_CR2;
        4'd3:    k = K_CR3;
        4'd4:    k = K_CR4;
        4'd8:    k = K_CR8;
        default: k = K_ILL;
      endcase
    end else if (int'(idx) == IDX_EFER) begin
      k = K_EFER;
    end else if (int'(idx) == IDX_CSA) begin
      k = K_CSA;
    end else if (int'(idx) >= IDX_SEG0 && int'(idx) < IDX_SEG0 + NSEG) begin
      k = K_SEG;
    end else begin
      k = K_ILL;
    end
    return k;
  endfunction

  // Paging-structure bits of CR4 whose change invalidates all translations.
  function automatic logic cr4_flush_needed(input logic [31:0] oldv,
                                            input logic [31:0] newv);
    logic [31:0] t;
    t = oldv ^ newv;
    return t[CR4_PSE] | t[CR4_PAE] | t[CR4_PGE];
  endfunction

  function automatic logic bit_rises(input logic oldb, input logic newb);
    return !oldb && newb;
  endfunction

  function automatic logic bit_falls(input logic oldb, input logic newb);
    return oldb && !newb;
  endfunction
endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import cr_side_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output wr_kind_e         kind,
  output logic [NSEG-1:0]  seg_sel
);
  assign kind = wr_en ? classify(wr_idx) : K_NONE;

  for (genvar i = 0; i < NSEG; i++) begin : g_sel
    assign seg_sel[i] = (kind == K_SEG) && (int'(wr_idx) == IDX_SEG0 + i);
  end
endmodule

// File: rtl/cr_ctrl_regs.sv
module cr_ctrl_regs
  import cr_side_pkg::*;
#(
  parameter int DW = 32   // at least 32: bit 31 of CR0 is paging
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_kind_e      kind,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cr0_q,
  output logic [DW-1:0] cr2_q,
  output logic [DW-1:0] cr3_q,
  output logic [DW-1:0] cr4_q,
  output logic [DW-1:0] cr8_q,
  output logic [DW-1:0] efer_q,
  output logic [DW-1:0] csa_q,
  output logic          flush_all,
  output logic          flush_ng,
  output logic          pg_toggle,
  output logic          lm_enter,
  output logic          lm_exit
);
  localparam logic [DW-1:0] ET_MASK = {{(DW-1){1'b0}}, 1'b1} << CR0_ET;

  logic cr4_flush;

  assign pg_toggle = (kind == K_CR0) && (cr0_q[CR0_PG] != wr_data[CR0_PG]);
  assign cr4_flush = (kind == K_CR4) && cr4_flush_needed(cr4_q[31:0], wr_data[31:0]);
  assign lm_enter  = (kind == K_CSA) && bit_rises(csa_q[CSA_LONG], wr_data[CSA_LONG]);
  assign lm_exit   = (kind == K_CSA) && bit_falls(csa_q[CSA_LONG], wr_data[CSA_LONG]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_q     <= ET_MASK;
      cr2_q     <= '0;
      cr3_q     <= '0;
      cr4_q     <= '0;
      cr8_q     <= '0;
      efer_q    <= '0;
      csa_q     <= '0;
      flush_all <= 1'b0;
      flush_ng  <= 1'b0;
    end else begin
      flush_all <= pg_toggle | cr4_flush;
      flush_ng  <= (kind == K_CR3);
      case (kind)
        K_CR0: begin
          cr0_q <= wr_data | ET_MASK;
          if (pg_toggle && efer_q[EFER_LME])
            efer_q[EFER_LMA] <= wr_data[CR0_PG];
        end
        K_CR2:   cr2_q  <= wr_data;
        K_CR3:   cr3_q  <= wr_data;
        K_CR4:   cr4_q  <= wr_data;
        K_CR8:   cr8_q  <= wr_data;
        K_EFER:  efer_q <= wr_data;
        K_CSA:   csa_q  <= wr_data;
        default: ;
      endcase
    end
  end

  // R2
  et_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CR0) |=> cr0_q[CR0_ET]);

  // R3
  lma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_toggle && efer_q[EFER_LME]) |=> (efer_q[EFER_LMA] == $past(wr_data[CR0_PG])));

  // R4
  pg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_toggle |=> flush_all);

  // R4
  flush_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(kind == K_CR0 || kind == K_CR4));

  // R5
  ng_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CR3) |=> (flush_ng && !flush_all));

  // R6
  cr4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CR4 && cr4_q[CR4_PSE] == wr_data[CR4_PSE] &&
     cr4_q[CR4_PAE] == wr_data[CR4_PAE] && cr4_q[CR4_PGE] == wr_data[CR4_PGE])
    |=> !flush_all);
endmodule

// File: rtl/seg_base_file.sv
module seg_base_file
  import cr_side_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSEG-1:0]    seg_we,
  input  logic [DW-1:0]      wr_data,
  input  logic               lma,
  input  logic               cs_long,
  input  logic               lm_enter,
  input  logic               lm_exit,
  output logic [NSEG*DW-1:0] base_q,
  output logic [NSEG*DW-1:0] eff_q,
  output logic               gate_open
);
  localparam int GW = NGATED * DW;

  logic gated_we;

  assign gate_open = !(lma && cs_long);
  assign gated_we  = |seg_we[NGATED-1:0];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [DW-1:0] base_r;
    logic [DW-1:0] eff_r;

    always_ff @(posedge clk) begin
      if (!rst_n) base_r <= '0;
      else if (seg_we[i]) base_r <= wr_data;
    end

    if (i < NGATED) begin : g_gated
      always_ff @(posedge clk) begin
        if (!rst_n)                       eff_r <= '0;
        else if (lm_enter)                eff_r <= '0;
        else if (lm_exit)                 eff_r <= base_r;
        else if (seg_we[i] && gate_open)  eff_r <= wr_data;
      end
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (!rst_n)         eff_r <= '0;
        else if (seg_we[i]) eff_r <= wr_data;
      end

      // R9
      free_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_we[i] |=> (eff_r == $past(wr_data)));
    end

    assign base_q[i*DW +: DW] = base_r;
    assign eff_q[i*DW +: DW]  = eff_r;
  end

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_we && !gate_open) |=> $stable(eff_q[GW-1:0]));

  // R7
  enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_enter |=> (eff_q[GW-1:0] == '0));

  // R7
  exit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_exit |=> (eff_q[GW-1:0] == $past(base_q[GW-1:0])));
endmodule

// File: rtl/cr_side_unit.sv
module cr_side_unit
  import cr_side_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [4:0]         wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      cr0_q,
  output logic [DW-1:0]      cr2_q,
  output logic [DW-1:0]      cr3_q,
  output logic [DW-1:0]      cr4_q,
  output logic [DW-1:0]      cr8_q,
  output logic [DW-1:0]      efer_q,
  output logic [DW-1:0]      cs_attr_q,
  output logic [6*DW-1:0]    seg_base_q,
  output logic [6*DW-1:0]    seg_eff_q,
  output logic               flush_all,
  output logic               flush_nonglobal,
  output logic               wr_illegal
);
  wr_kind_e        kind;
  logic [NSEG-1:0] seg_sel;
  logic            pg_toggle;
  logic            lm_enter;
  logic            lm_exit;
  logic            gate_open;

  cr_decode u_decode (
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .kind    (kind),
    .seg_sel (seg_sel)
  );

  cr_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .wr_data   (wr_data),
    .cr0_q     (cr0_q),
    .cr2_q     (cr2_q),
    .cr3_q     (cr3_q),
    .cr4_q     (cr4_q),
    .cr8_q     (cr8_q),
    .efer_q    (efer_q),
    .csa_q     (cs_attr_q),
    .flush_all (flush_all),
    .flush_ng  (flush_nonglobal),
    .pg_toggle (pg_toggle),
    .lm_enter  (lm_enter),
    .lm_exit   (lm_exit)
  );

  seg_base_file #(.DW(DW)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_we    (seg_sel),
    .wr_data   (wr_data),
    .lma       (efer_q[EFER_LMA]),
    .cs_long   (cs_attr_q[CSA_LONG]),
    .lm_enter  (lm_enter),
    .lm_exit   (lm_exit),
    .base_q    (seg_base_q),
    .eff_q     (seg_eff_q),
    .gate_open (gate_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wr_illegal <= 1'b0;
    else        wr_illegal <= (kind == K_ILL);
  end

  // R10
  illegal_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_ILL) |=> (wr_illegal && !flush_all && !flush_nonglobal &&
      $stable(cr0_q) && $stable(cr4_q) && $stable(efer_q) && $stable(cs_attr_q) &&
      $stable(seg_base_q) && $stable(seg_eff_q)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!flush_all && !flush_nonglobal && !wr_illegal && $stable(cr0_q) &&
      $stable(seg_eff_q)));
endmodule

// File: tb/cr_side_unit_tb.sv
module cr_side_unit_tb;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   cr0_q, cr2_q, cr3_q, cr4_q, cr8_q, efer_q, cs_attr_q;
  logic [191:0]  seg_base_q, seg_eff_q;
  logic          flush_all, flush_nonglobal, wr_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model
  logic [31:0] m_cr0, m_cr2, m_cr3, m_cr4, m_cr8, m_efer, m_csa;
  logic [31:0] m_base [6];
  logic [31:0] m_eff  [6];

  always #10 clk = ~clk;

  cr_side_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cr0_q(cr0_q), .cr2_q(cr2_q), .cr3_q(cr3_q), .cr4_q(cr4_q), .cr8_q(cr8_q),
    .efer_q(efer_q), .cs_attr_q(cs_attr_q), .seg_base_q(seg_base_q),
    .seg_eff_q(seg_eff_q), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
    .wr_illegal(wr_illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, "cr0", cr0_q, m_cr0);
    chk(req, "cr2", cr2_q, m_cr2);
    chk(req, "cr3", cr3_q, m_cr3);
    chk(req, "cr4", cr4_q, m_cr4);
    chk(req, "cr8", cr8_q, m_cr8);
    chk(req, "efer", efer_q, m_efer);
    chk(req, "csattr", cs_attr_q, m_csa);
    for (int s = 0; s < 6; s++) begin
      chk(req, $sformatf("base%0d", s), seg_base_q[s*32 +: 32], m_base[s]);
      chk(req, $sformatf("eff%0d", s), seg_eff_q[s*32 +: 32], m_eff[s]);
    end
  endtask

  task automatic chk_pulses(input string req, input bit fa, input bit fn, input bit il);
    chk(req, "flush_all", {31'b0, flush_all}, {31'b0, fa});
    chk(req, "flush_nonglobal", {31'b0, flush_nonglobal}, {31'b0, fn});
    chk(req, "wr_illegal", {31'b0, wr_illegal}, {31'b0, il});
  endtask

  // Write with the model updated from the requirement text.
  task automatic wr(input string req, input logic [4:0] idx, input logic [31:0] d);
    bit fa = 0, fn = 0, il = 0;
    int s;
    case (idx)
      5'd0: begin
        fa = m_cr0[31] ^ d[31];
        if (fa && m_efer[8]) m_efer[10] = d[31];
        m_cr0 = d | 32'h10;
      end
      5'd2: m_cr2 = d;
      5'd3: begin m_cr3 = d; fn = 1; end
      5'd4: begin fa = ((m_cr4 ^ d) & 32'hB0) != 0; m_cr4 = d; end
      5'd8: m_cr8 = d;
      5'd16: m_efer = d;
      5'd17: begin
        if (!m_csa[0] && d[0]) for (int k = 0; k < 4; k++) m_eff[k] = 32'h0;
        else if (m_csa[0] && !d[0]) for (int k = 0; k < 4; k++) m_eff[k] = m_base[k];
        m_csa = d;
      end
      5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23: begin
        s = int'(idx) - 18;
        m_base[s] = d;
        if (s >= 4 || !(m_efer[10] && m_csa[0])) m_eff[s] = d;
      end
      default: il = 1;
    endcase
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk_state(req);
    chk_pulses(req, fa, fn, il);
    @(negedge clk);
    chk_pulses("R4", 0, 0, 0);   // pulses last one cycle only
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    m_cr0 = 32'h10; m_cr2 = 0; m_cr3 = 0; m_cr4 = 0; m_cr8 = 0; m_efer = 0; m_csa = 0;
    for (int s = 0; s < 6; s++) begin m_base[s] = 0; m_eff[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1");
    chk_pulses("R1", 0, 0, 0);

    // R5 CR3 writes, repeated value still flushes
    wr("R5", 5'd3, 32'h0000_5000);
    wr("R5", 5'd3, 32'h0000_5000);

    // R2 ET forced
    wr("R2", 5'd0, 32'h0000_0000);
    wr("R2", 5'd0, 32'h0000_0021);

    // R6 every single-bit CR4 toggle
    v = 32'h0;
    for (int b = 0; b < 32; b++) begin
      v = v ^ (32'h1 << b);
      wr("R6", 5'd4, v);
    end
    wr("R6", 5'd4, v);

    // R3 R4 paging toggle without long enable: no LMA change
    wr("R3", 5'd0, 32'h8000_0001);
    wr("R3", 5'd0, 32'h0000_0001);

    // R11 plain registers
    wr("R11", 5'd2, 32'hDEAD_BEEF);
    wr("R11", 5'd8, 32'h0000_000F);
    wr("R11", 5'd16, 32'h0000_0100);

    // R3 long enable set: paging on/off drives LMA
    wr("R3", 5'd0, 32'h8000_0001);
    wr("R3", 5'd0, 32'h8000_0003);
    wr("R3", 5'd0, 32'h0000_0001);

    // R7 R8 R9 sweep of long-active x code-long
    for (int la = 0; la < 2; la++) begin
      for (int cl = 0; cl < 2; cl++) begin
        wr("R11", 5'd16, la ? 32'h0000_0500 : 32'h0000_0100);
        wr("R7", 5'd17, {31'h0000_0A00 >> 1, cl[0]});
        for (int s = 0; s < 6; s++)
          wr(s < 4 ? "R8" : "R9", 5'(18 + s), 32'h1000_0000 + 32'(la * 64 + cl * 16 + s));
        wr("R7", 5'd17, {31'h0000_0C00 >> 1, cl[0]});   // long kept: no change
        wr("R7", 5'd17, {31'h0, ~cl[0]});               // long toggles
        wr("R7", 5'd17, 32'h0);                         // back to 0 (reload)
      end
    end

    // R10 illegal index sweep
    for (int i = 0; i < 32; i++) begin
      if (i == 1 || (i >= 5 && i <= 7) || (i >= 9 && i <= 15) || i >= 24)
        wr("R10", 5'(i), 32'hFFFF_FFFF);
    end

    // R11 disabled write has no effect
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 5'd3; wr_data = 32'h1234_5678;
    @(negedge clk);
    chk_state("R11");
    chk_pulses("R11", 0, 0, 0);
    wr_idx = 5'd1;
    @(negedge clk);
    chk_pulses("R11", 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule